// File: doc/BRIEF.md
# Exception Entry Stack Alignment Unit

This unit handles the stack side of taking and leaving an exception in a small 32-bit processor model. On entry it takes the current stack pointer, the status word and seven general registers. It decides whether one padding word is needed so that the frame starts on an 8-byte boundary. It then writes an eight-word frame through a word-wide memory port, one word per clock, and reports the new stack pointer. The stacked status word carries a flag in bit 9 that records whether padding was applied.

On return it is given the frame address as its stack pointer. It reads the eight words back, highest address first, and uses the stacked bit 9 to undo any padding. It then presents the original stack pointer, the restored registers and a status value with the flag cleared. A control input picks 8-byte alignment or plain 4-byte alignment for entries.

The sequencer has four states:
- IDLE: waits for a request. An accepted entry request moves it to PUSH, and an accepted return request moves it to POP.
- PUSH: writes one frame word per cycle, highest address first.
- POP: reads one frame word per cycle, highest address first.
- FINISH: raises the done pulse for one cycle and then goes back to IDLE.

PUSH and POP move to FINISH after the word at the frame base.

Top module: `exc_stack_align`

## Requirements
- R1: With `align8_en` low, an entry gives `sp_out` = `sp_in` − 32 and stacks bit 9 of the status word as 0, whatever `sp_in[2]` is.
- R2: With `align8_en` high and `sp_in[2]` = 1, an entry skips one padding word: `sp_out` = `sp_in` − 36, which is a multiple of 8, and the stacked status bit 9 is 1.
- R3: With `align8_en` high and `sp_in[2]` = 0, an entry gives `sp_out` = `sp_in` − 32 and the stacked status bit 9 is 0.
- R4: The stacked status word (`psr_stacked`, also the word written at frame base + 28) equals `psr_in` in every bit except bit 9. Bit 9 is replaced by the padding flag.
- R5: The frame word at base + 4k holds, for k = 0..7: R0, R1, R2, R3, R12, LR, return PC, status. Register k is `regs_in[32k+31:32k]`. Exactly eight writes are made, one per cycle, at descending addresses starting at base + 28.
- R6: A return request with `sp_in` = frame base makes eight reads at descending addresses. It sets `sp_out` = base + 32 + 4·(stacked bit 9), independent of `align8_en`, and places stacked word k in `regs_out[32k+31:32k]` for k = 0..6.
- R7: On return, `psr_restore` equals the stacked status word with bit 9 cleared.
- R8: `busy` rises in the cycle after a request is accepted and stays high for 9 cycles. `done` is high only in the ninth of these cycles, and results are valid when `done` is high.
- R9: A request whose `sp_in[1:0]` is not 00 is rejected. `sp_err` is high for one cycle, there is no memory access, and `sp_out` is unchanged.
- R10: Requests made while `busy` is high are ignored. When entry and return are requested in the same idle cycle, only the entry is carried out.
- R11: After reset, `busy`, `done`, `mem_we`, `mem_re`, `sp_err` and `sp_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| align8_en | input | 1 | 1: entry frames are aligned to 8 bytes; 0: 4-byte alignment |
| entry_req | input | 1 | Start an exception entry (sampled in IDLE) |
| ret_req | input | 1 | Start an exception return (sampled in IDLE) |
| sp_in | input | 32 | Stack pointer at entry, or frame base at return |
| psr_in | input | 32 | Status word to stack on entry |
| regs_in | input | 224 | R0, R1, R2, R3, R12, LR, PC packed 32 bits each, R0 lowest |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Word address of the current access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as `mem_addr` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| sp_out | output | 32 | Stack pointer after the last entry or return |
| psr_stacked | output | 32 | Status word stacked by the last entry |
| psr_restore | output | 32 | Status word restored by the last return, flag cleared |
| regs_out | output | 224 | Registers restored by the last return |
| sp_err | output | 1 | One-cycle pulse for a rejected misaligned request |

## Verification
Entries are tried with three stack pointers: one ending in 4 with alignment off, one ending in 4 with alignment on, and one already on an 8-byte boundary with alignment on. Together these separate the alignment decision from the `sp_in[2]` test and show that padding only moves the frame base. Each entry is undone by a return. One return is made with alignment switched off over a padded frame, which shows that the return depends only on the stacked flag. A status input with bit 9 already set shows that the flag overwrites rather than ORs. Misaligned pointers, requests while busy and simultaneous requests separate rejection, ignoring and priority.

// File: rtl/esa_pkg.sv
package esa_pkg;
    localparam int ESA_WORD_BYTES = 4;
    localparam int ESA_FRAME_WORDS = 8;
    localparam int ESA_PAD_BIT = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_FINISH
    } seq_state_t;

    typedef enum logic {
        OP_ENTRY,
        OP_RETURN
    } seq_op_t;
endpackage

// File: rtl/esa_entry_calc.sv
module esa_entry_calc
    import esa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAME_WORDS = ESA_FRAME_WORDS,
    parameter int PAD_BIT = ESA_PAD_BIT
) (
    input  logic              align8_en,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] psr_in,
    output logic              need_pad,
    output logic [DATA_W-1:0] frame_base,
    output logic [DATA_W-1:0] psr_frame
);
    localparam int FRAME_BYTES = FRAME_WORDS * ESA_WORD_BYTES;

    logic [DATA_W-1:0] raw_base;

    always_comb begin
        raw_base = sp_in - DATA_W'(FRAME_BYTES);
        // Padding applies only when 8-byte alignment is on and the pointer is word-odd
        need_pad = align8_en & sp_in[2];
        frame_base = need_pad ? {raw_base[DATA_W-1:3], 3'b000} : raw_base;
        psr_frame = psr_in;
        psr_frame[PAD_BIT] = need_pad;
    end
endmodule

// File: rtl/esa_return_calc.sv
module esa_return_calc
    import esa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAME_WORDS = ESA_FRAME_WORDS,
    parameter int PAD_BIT = ESA_PAD_BIT
) (
    input  logic [DATA_W-1:0] frame_base,
    input  logic [DATA_W-1:0] stacked_psr,
    output logic [DATA_W-1:0] sp_restored,
    output logic [DATA_W-1:0] psr_clean
);
    localparam int FRAME_BYTES = FRAME_WORDS * ESA_WORD_BYTES;

    always_comb begin
        sp_restored = frame_base + DATA_W'(FRAME_BYTES)
                    + (stacked_psr[PAD_BIT] ? DATA_W'(ESA_WORD_BYTES) : '0);
        psr_clean = stacked_psr;
        psr_clean[PAD_BIT] = 1'b0;
    end
endmodule

// File: rtl/esa_seq.sv
module esa_seq
    import esa_pkg::*;
#(
    parameter int FRAME_WORDS = ESA_FRAME_WORDS,
    localparam int IDX_W = $clog2(FRAME_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_entry,
    input  logic             start_ret,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy,
    output logic             done,
    output logic             xfer_we,
    output logic             xfer_re,
    output logic             last_xfer
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_entry) begin
                    state_d = ST_PUSH;
                    idx_d = LAST_IDX;
                end else if (start_ret) begin
                    state_d = ST_POP;
                    idx_d = LAST_IDX;
                end
            end
            ST_PUSH, ST_POP: begin
                if (idx_q == '0) state_d = ST_FINISH;
                else idx_d = idx_q - 1'b1;
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q <= idx_d;
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        xfer_we = 1'b0;
        xfer_re = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH: begin
                busy = 1'b1;
                xfer_we = 1'b1;
            end
            ST_POP: begin
                busy = 1'b1;
                xfer_re = 1'b1;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
        endcase
        last_xfer = (xfer_we | xfer_re) & (idx_q == '0);
        idx_o = idx_q;
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_xfer |=> done);
endmodule

// File: rtl/exc_stack_align.sv
module exc_stack_align
    import esa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAME_WORDS = ESA_FRAME_WORDS,
    parameter int PAD_BIT = ESA_PAD_BIT,
    localparam int GPR_W = (FRAME_WORDS - 1) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align8_en,
    input  logic              entry_req,
    input  logic              ret_req,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] psr_in,
    input  logic [GPR_W-1:0]  regs_in,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] psr_stacked,
    output logic [DATA_W-1:0] psr_restore,
    output logic [GPR_W-1:0]  regs_out,
    output logic              sp_err
);
    localparam int IDX_W = $clog2(FRAME_WORDS);
    localparam logic [IDX_W-1:0] STATUS_IDX = IDX_W'(FRAME_WORDS - 1);

    logic              misaligned, accept_entry, accept_ret, reject;
    logic              need_pad;
    logic [DATA_W-1:0] entry_base, psr_frame, sp_restored, psr_clean;
    logic [IDX_W-1:0]  idx;
    logic              xfer_we, xfer_re, last_xfer;

    logic [DATA_W-1:0] base_q, psr_frame_q, stat_q, sp_out_q, psr_restore_q;
    logic [GPR_W-1:0]  regs_q, regs_out_q;
    logic              align_q, sp_err_q;
    seq_op_t           op_q;

    always_comb begin
        misaligned = |sp_in[1:0];
        accept_entry = !busy && entry_req && !misaligned;
        accept_ret = !busy && ret_req && !entry_req && !misaligned;
        reject = !busy && (entry_req || ret_req) && misaligned;
    end

    esa_entry_calc #(.DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS), .PAD_BIT(PAD_BIT)) u_entry (
        .align8_en (align8_en),
        .sp_in     (sp_in),
        .psr_in    (psr_in),
        .need_pad  (need_pad),
        .frame_base(entry_base),
        .psr_frame (psr_frame)
    );

    esa_return_calc #(.DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS), .PAD_BIT(PAD_BIT)) u_ret (
        .frame_base (base_q),
        .stacked_psr(stat_q),
        .sp_restored(sp_restored),
        .psr_clean  (psr_clean)
    );

    esa_seq #(.FRAME_WORDS(FRAME_WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_entry(accept_entry),
        .start_ret  (accept_ret),
        .idx_o      (idx),
        .busy       (busy),
        .done       (done),
        .xfer_we    (xfer_we),
        .xfer_re    (xfer_re),
        .last_xfer  (last_xfer)
    );

    // memory port: word idx sits at base + 4*idx
    always_comb begin
        mem_we = xfer_we;
        mem_re = xfer_re;
        mem_addr = base_q + DATA_W'({idx, 2'b00});
        if (idx == STATUS_IDX) mem_wdata = psr_frame_q;
        else mem_wdata = regs_q[int'(idx)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            psr_frame_q <= '0;
            regs_q <= '0;
            align_q <= 1'b0;
            op_q <= OP_ENTRY;
            stat_q <= '0;
            regs_out_q <= '0;
            sp_out_q <= '0;
            psr_restore_q <= '0;
            sp_err_q <= 1'b0;
        end else begin
            sp_err_q <= reject;
            if (accept_entry) begin
                base_q <= entry_base;
                psr_frame_q <= psr_frame;
                regs_q <= regs_in;
                align_q <= align8_en;
                op_q <= OP_ENTRY;
            end else if (accept_ret) begin
                base_q <= sp_in;
                op_q <= OP_RETURN;
            end
            if (xfer_re) begin
                if (idx == STATUS_IDX) stat_q <= mem_rdata;
                else regs_out_q[int'(idx)*DATA_W +: DATA_W] <= mem_rdata;
            end
            if (xfer_we && last_xfer) sp_out_q <= base_q;
            if (xfer_re && last_xfer) begin
                sp_out_q <= sp_restored;
                psr_restore_q <= psr_clean;
            end
        end
    end

    assign sp_out = sp_out_q;
    assign psr_stacked = psr_frame_q;
    assign psr_restore = psr_restore_q;
    assign regs_out = regs_out_q;
    assign sp_err = sp_err_q;

    assert_push_descending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - DATA_W'(ESA_WORD_BYTES));
    assert_pop_descending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) - DATA_W'(ESA_WORD_BYTES));
    assert_padded_sp_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_ENTRY && align_q) |-> sp_out[2:0] == 3'b000);
    assert_no_flag_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_ENTRY && !align_q) |-> !psr_stacked[PAD_BIT]);
    assert_reject_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_err |-> (!busy && !mem_we && !mem_re));
    assert_ignore_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_exc_stack_align.sv
`timescale 1ns/1ps
module sim_exc_stack_align;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         align8_en = 1'b0, entry_req = 1'b0, ret_req = 1'b0;
    logic [31:0]  sp_in = '0, psr_in = '0;
    logic [223:0] regs_in = '0;
    logic         mem_we, mem_re, busy, done, sp_err;
    logic [31:0]  mem_addr, mem_wdata, mem_rdata, sp_out, psr_stacked, psr_restore;
    logic [223:0] regs_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    exc_stack_align u0 (
        .clk(clk), .rst_n(rst_n), .align8_en(align8_en), .entry_req(entry_req),
        .ret_req(ret_req), .sp_in(sp_in), .psr_in(psr_in), .regs_in(regs_in),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out),
        .psr_stacked(psr_stacked), .psr_restore(psr_restore), .regs_out(regs_out),
        .sp_err(sp_err)
    );

    // bench memory: 1 KiB window, combinational read
    logic [31:0] mem [0:255];
    logic [31:0] wlog [0:63];
    int wcnt = 0;
    int rcnt = 0;
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wlog[wcnt % 64] <= mem_addr;
            wcnt <= wcnt + 1;
        end
        if (mem_re) rcnt <= rcnt + 1;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [223:0] make_regs(input logic [31:0] seed);
        logic [223:0] r;
        for (int k = 0; k < 7; k++) r[k*32 +: 32] = 32'hC0DE_0000 ^ (seed << 4) ^ k;
        return r;
    endfunction

    // waits for done after a one-cycle request; returns cycles from accept edge
    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy", {31'b0, busy}, 32'd0);
        chk("R11 done", {31'b0, done}, 32'd0);
        chk("R11 strobes", {30'b0, mem_we, mem_re}, 32'd0);
        chk("R11 sp_err", {31'b0, sp_err}, 32'd0);
        chk("R11 sp_out", sp_out, 32'd0);
    endtask

    task automatic t_entry(input string req, input logic [31:0] sp, input logic [31:0] psr,
                           input logic al, input logic [31:0] exp_sp, input logic exp_pad,
                           output logic [223:0] used_regs);
        int w0, n;
        logic [31:0] exp_psr;
        logic [223:0] rg;
        rg = make_regs(sp);
        used_regs = rg;
        exp_psr = psr;
        exp_psr[9] = exp_pad;
        w0 = wcnt;
        sp_in = sp; psr_in = psr; align8_en = al; regs_in = rg; entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        chk("R8 busy after accept", {31'b0, busy}, 32'd1);
        wait_done(n);
        chk("R8 entry latency", n, 9);
        chk({req, " sp_out"}, sp_out, exp_sp);
        chk("R4 stacked status", psr_stacked, exp_psr);
        chk("R5 write count", wcnt - w0, 8);
        for (int k = 0; k < 8; k++)
            chk("R5 write order", wlog[(w0 + k) % 64], exp_sp + 32'(4 * (7 - k)));
        for (int k = 0; k < 7; k++)
            chk("R5 frame word", mem[(exp_sp[9:2] + 8'(k))], rg[k*32 +: 32]);
        chk("R4 frame status word", mem[exp_sp[9:2] + 8'd7], exp_psr);
        @(negedge clk);
        chk("R8 idle after done", {30'b0, busy, done}, 32'd0);
    endtask

    task automatic t_return(input logic [31:0] frame, input logic al, input logic [31:0] exp_sp,
                            input logic [31:0] exp_psr, input logic [223:0] exp_regs);
        int r0, n;
        r0 = rcnt;
        sp_in = frame; align8_en = al; ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_done(n);
        chk("R8 return latency", n, 9);
        chk("R6 read count", rcnt - r0, 8);
        chk("R6 restored sp", sp_out, exp_sp);
        chk("R7 restored status", psr_restore, exp_psr);
        for (int k = 0; k < 7; k++)
            chk("R6 restored reg", regs_out[k*32 +: 32], exp_regs[k*32 +: 32]);
        @(negedge clk);
    endtask

    task automatic t_misaligned(input logic is_ret);
        int w0, r0;
        logic [31:0] sp_before;
        w0 = wcnt; r0 = rcnt; sp_before = sp_out;
        sp_in = 32'h2000_0102; entry_req = !is_ret; ret_req = is_ret;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
        chk("R9 sp_err pulse", {31'b0, sp_err}, 32'd1);
        chk("R9 not busy", {31'b0, busy}, 32'd0);
        @(negedge clk);
        chk("R9 sp_err one cycle", {31'b0, sp_err}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R9 no access", (wcnt - w0) + (rcnt - r0), 0);
        chk("R9 sp_out kept", sp_out, sp_before);
    endtask

    task automatic t_busy_ignore();
        int w0, r0, n;
        w0 = wcnt; r0 = rcnt;
        sp_in = 32'h2000_0100; align8_en = 1'b1; psr_in = 32'h1; regs_in = make_regs(32'h5);
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        @(negedge clk);
        entry_req = 1'b1; ret_req = 1'b1; sp_in = 32'h2000_0054;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
        n = 3;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R10 latency unaffected", n, 9);
        chk("R10 sp_out from first request", sp_out, 32'h2000_00E0);
        chk("R10 writes", wcnt - w0, 8);
        chk("R10 no reads", rcnt - r0, 0);
        repeat (3) @(negedge clk);
        chk("R10 no restart", {31'b0, busy}, 32'd0);
    endtask

    task automatic t_priority();
        int w0, r0, n;
        w0 = wcnt; r0 = rcnt;
        sp_in = 32'h2000_0100; align8_en = 1'b0; psr_in = 32'h2;
        entry_req = 1'b1; ret_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
        wait_done(n);
        chk("R10 entry wins sp", sp_out, 32'h2000_00E0);
        chk("R10 entry wins writes", wcnt - w0, 8);
        chk("R10 entry wins no reads", rcnt - r0, 0);
        @(negedge clk);
    endtask

    initial begin
        logic [223:0] ra, rb, rc;
        t_reset();
        // R1: alignment off, word-odd pointer, input flag already set
        t_entry("R1", 32'h2000_0104, 32'h0100_0203, 1'b0, 32'h2000_00E4, 1'b0, ra);
        t_return(32'h2000_00E4, 1'b0, 32'h2000_0104, 32'h0100_0003, ra);
        // R2: alignment on, word-odd pointer -> padding
        t_entry("R2", 32'h2000_0104, 32'h6100_0010, 1'b1, 32'h2000_00E0, 1'b1, rb);
        // R6: return with alignment off still honours the stacked flag
        t_return(32'h2000_00E0, 1'b0, 32'h2000_0104, 32'h6100_0010, rb);
        // R3: alignment on, already 8-aligned -> no padding
        t_entry("R3", 32'h2000_00F8, 32'h8000_0000, 1'b1, 32'h2000_00D8, 1'b0, rc);
        t_return(32'h2000_00D8, 1'b1, 32'h2000_00F8, 32'h8000_0000, rc);
        t_misaligned(1'b0);
        t_misaligned(1'b1);
        t_busy_ignore();
        t_priority();
        summary();
    end
endmodule